// File: doc/BRIEF.md
# Coarse-Fine Pulse Width Digitizer

The block measures how long a single transient pulse stays high. While the pulse is present, and before the lockout engages, the block enables a gated ring of odd length. Each clock cycle of the model stands for one inverter delay step, and the ring's node levels arrive on `ring_i` as a sampled phase vector. A coarse counter counts full ring periods by watching the ring's last node fall. A bank of per-node latches follows the ring and freezes its pattern when the measurement closes. The frozen pattern decodes to a sub-period step index, which gives resolution down to one stage delay.

A one-shot detector records that a pulse was seen. Once the input has then stayed low for a set number of samples, the detector locks, gates the ring off and raises `valid_o`. Any later pulse is ignored until the next synchronous initialize. A pulse that resumes before the lockout engages extends the same measurement, so the result is the sum of both widths. The readout gives the coarse count, the raw latch pattern, the decoded step and a combined width code in step units.

Top module: `tdc_pulse_digitizer`

## Requirements
- R1: After reset or one clock with `init_i` high, `coarse_o` is 0, `fine_o` holds the idle ring pattern 7'b1010101 (bit k is node k, and even nodes idle high), `step_o` and `width_o` are 0, and `valid_o`, `ovf_o` and `err_o` are low.
- R2: While not locked, `osc_en_o` follows `pulse_i`. Each clock edge with `osc_en_o` high advances the external ring by one step.
- R3: `coarse_o` increments once for every high-to-low change of ring node 6 (bit 6 of `ring_i`) seen while not locked. After T ring steps from idle it equals floor((T+7)/14).
- R4: `fine_o` copies `ring_i` on every clock edge until the lock engages, and then holds its value.
- R5: `step_o` decodes the latched pattern to an index s in 0..13. For s ≤ 7, pattern s is the idle pattern with nodes 0..s-1 inverted. For s > 7, nodes s-7..6 are inverted. After T steps, s = T mod 14.
- R6: `width_o` = 14·`coarse_o` + `step_o`, less 14 when `step_o` ≥ 7. For a legal, unsaturated run it equals the number of steps T.
- R7: Once a pulse has been seen, two consecutive low samples of `pulse_i` engage the lock. `valid_o` then stays high and `osc_en_o` stays low until the next initialize, even if `pulse_i` rises again.
- R8: A pulse that resumes after a single low sample is still measured. Its steps add to the first pulse's steps.
- R9: `coarse_o` stops at 255 instead of wrapping. A further node-6 fall sets `ovf_o`, which stays high until initialize.
- R10: A latched pattern that matches none of the 14 legal ring states sets `err_o` and forces `step_o` and `width_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Step clock, one edge per stage delay |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous initialize of counter, latches and detector |
| pulse_i | input | 1 | Pulse under measurement |
| ring_i | input | 7 | Sampled ring node levels, bit k is node k |
| osc_en_o | output | 1 | Ring enable (pulse gated by lockout) |
| coarse_o | output | 8 | Full ring periods counted |
| fine_o | output | 7 | Frozen ring node pattern |
| step_o | output | 4 | Decoded sub-period step index |
| width_o | output | 12 | Combined width in step units |
| valid_o | output | 1 | Measurement closed and locked |
| ovf_o | output | 1 | Coarse counter saturated |
| err_o | output | 1 | Latched pattern is not a legal ring state |

## Verification
Several properties are checked on every cycle: the lockout blocks the enable, the latches and counter hold after lock, the coarse count never decreases between initializes, saturation is consistent with the overflow flag, and an illegal pattern zeroes the width. The correct mapping from pulse length to coarse count, step index and width code shows only in the bench's scenarios. So do the summing of a pulse that resumes after a one-sample gap, the rejection of a pulse after a two-sample gap, and the exact saturation point. The bench drives these against a ring model of its own.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    parameter int STAGES_DEF   = 7;
    parameter int CNT_W_DEF    = 8;
    parameter int LOCK_LAT_DEF = 2;
endpackage

// File: rtl/tdc_lockout.sv
module tdc_lockout #(
    parameter int LOCK_LAT = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic init_i,
    input  logic pulse_i,
    output logic gate_o,
    output logic lock_o
);
    localparam int LOW_W = $clog2(LOCK_LAT + 1);

    typedef struct packed {
        logic             seen;
        logic [LOW_W-1:0] low;
        logic             lock;
    } lock_st_t;

    lock_st_t st_q, st_d;

    assign gate_o = pulse_i & ~st_q.lock;
    assign lock_o = st_q.lock;

    always_comb begin
        st_d = st_q;
        if (init_i) begin
            st_d = '0;
        end else if (gate_o) begin
            st_d.seen = 1'b1;
            st_d.low  = '0;
        end else if (st_q.seen && !st_q.lock) begin
            if (st_q.low == LOW_W'(LOCK_LAT - 1)) begin
                st_d.lock = 1'b1;
            end else begin
                st_d.low = st_q.low + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/tdc_coarse.sv
module tdc_coarse #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             init_i,
    input  logic             hold_i,
    input  logic             tap_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev;
        logic             ovf;
    } cnt_st_t;

    cnt_st_t st_q, st_d;

    assign count_o = st_q.cnt;
    assign ovf_o   = st_q.ovf;

    always_comb begin
        st_d      = st_q;
        st_d.prev = tap_i;
        if (init_i) begin
            st_d.cnt  = '0;
            st_d.ovf  = 1'b0;
            st_d.prev = 1'b1;
        end else if (!hold_i && st_q.prev && !tap_i) begin
            if (st_q.cnt == CNT_MAX) st_d.ovf = 1'b1;
            else                     st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: '0, prev: 1'b1, ovf: 1'b0};
        else         st_q <= st_d;
    end
endmodule

// File: rtl/tdc_fine.sv
module tdc_fine #(
    parameter int STAGES = 7,
    parameter int STEP_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              init_i,
    input  logic              hold_i,
    input  logic [STAGES-1:0] ring_i,
    output logic [STAGES-1:0] snap_o,
    output logic [STEP_W-1:0] step_o,
    output logic              legal_o
);
    localparam int STEPS = 2 * STAGES;

    function automatic logic [STAGES-1:0] pat_of(input int s);
        logic [STAGES-1:0] p;
        for (int k = 0; k < STAGES; k++) begin
            p[k] = ((k % 2) == 0) ^ ((s <= STAGES) ? (k < s) : (k >= s - STAGES));
        end
        return p;
    endfunction

    localparam logic [STAGES-1:0] IDLE = pat_of(0);

    typedef struct packed {
        logic [STAGES-1:0] snap;
    } fine_st_t;

    fine_st_t st_q, st_d;
    logic [STEPS-1:0] hit;

    always_comb begin
        st_d = st_q;
        if (init_i)       st_d.snap = IDLE;
        else if (!hold_i) st_d.snap = ring_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{snap: IDLE};
        else         st_q <= st_d;
    end

    for (genvar s = 0; s < STEPS; s++) begin : g_match
        assign hit[s] = (st_q.snap == pat_of(s));
    end

    always_comb begin
        step_o = '0;
        for (int s = 0; s < STEPS; s++) begin
            if (hit[s]) step_o = STEP_W'(s);
        end
    end

    assign legal_o = |hit;
    assign snap_o  = st_q.snap;
endmodule

// File: rtl/tdc_pulse_digitizer.sv
module tdc_pulse_digitizer #(
    parameter int STAGES   = tdc_pkg::STAGES_DEF,
    parameter int CNT_W    = tdc_pkg::CNT_W_DEF,
    parameter int LOCK_LAT = tdc_pkg::LOCK_LAT_DEF,
    localparam int STEPS   = 2 * STAGES,
    localparam int STEP_W  = $clog2(STEPS),
    localparam int WID_W   = CNT_W + STEP_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              init_i,
    input  logic              pulse_i,
    input  logic [STAGES-1:0] ring_i,
    output logic              osc_en_o,
    output logic [CNT_W-1:0]  coarse_o,
    output logic [STAGES-1:0] fine_o,
    output logic [STEP_W-1:0] step_o,
    output logic [WID_W-1:0]  width_o,
    output logic              valid_o,
    output logic              ovf_o,
    output logic              err_o
);
    logic              lock;
    logic              legal;
    logic [STEP_W-1:0] step_raw;

    tdc_lockout #(.LOCK_LAT(LOCK_LAT)) u_lock (
        .clk_i (clk_i), .rst_ni(rst_ni), .init_i(init_i),
        .pulse_i(pulse_i), .gate_o(osc_en_o), .lock_o(lock)
    );

    tdc_coarse #(.CNT_W(CNT_W)) u_coarse (
        .clk_i (clk_i), .rst_ni(rst_ni), .init_i(init_i), .hold_i(lock),
        .tap_i (ring_i[STAGES-1]), .count_o(coarse_o), .ovf_o(ovf_o)
    );

    tdc_fine #(.STAGES(STAGES), .STEP_W(STEP_W)) u_fine (
        .clk_i (clk_i), .rst_ni(rst_ni), .init_i(init_i), .hold_i(lock),
        .ring_i(ring_i), .snap_o(fine_o), .step_o(step_raw), .legal_o(legal)
    );

    // The tap node falls at the mid-period step, so an upper-half step has
    // already been counted once in the coarse value.
    always_comb begin
        logic             upper;
        logic [WID_W-1:0] total;
        upper = (step_raw >= STEP_W'(STAGES));
        total = WID_W'(coarse_o) * WID_W'(STEPS) + WID_W'(step_raw);
        if (upper) total = total - WID_W'(STEPS);
        err_o   = !legal || (upper && (coarse_o == '0));
        step_o  = err_o ? '0 : step_raw;
        width_o = err_o ? '0 : total;
    end

    assign valid_o = lock;
endmodule

// File: rtl/tdc_pulse_digitizer_chk.sv
module tdc_pulse_digitizer_chk #(
    parameter int STAGES = 7,
    parameter int CNT_W  = 8,
    parameter int STEP_W = 4,
    parameter int WID_W  = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              init_i,
    input logic              pulse_i,
    input logic              osc_en_o,
    input logic [CNT_W-1:0]  coarse_o,
    input logic [STAGES-1:0] fine_o,
    input logic [WID_W-1:0]  width_o,
    input logic              valid_o,
    input logic              ovf_o,
    input logic              err_o
);
    assert_init_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_i |=> (coarse_o == '0 && !valid_o && !ovf_o && !err_o));

    assert_coarse_monotonic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !init_i |=> coarse_o >= $past(coarse_o));

    assert_hold_after_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !init_i) |=> ($stable(fine_o) && $stable(coarse_o)));

    assert_locked_no_osc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> !osc_en_o);

    assert_valid_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !init_i) |=> valid_o);

    assert_no_overflow_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (coarse_o == '1));

    assert_err_zero_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (width_o == '0));
endmodule

bind tdc_pulse_digitizer tdc_pulse_digitizer_chk #(
    .STAGES(STAGES), .CNT_W(CNT_W), .STEP_W(STEP_W), .WID_W(WID_W)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .pulse_i(pulse_i),
    .osc_en_o(osc_en_o), .coarse_o(coarse_o), .fine_o(fine_o), .width_o(width_o),
    .valid_o(valid_o), .ovf_o(ovf_o), .err_o(err_o)
);

// File: tb/tdc_pulse_digitizer_tb_top.sv
`timescale 1ns/1ps
module tdc_pulse_digitizer_tb_top;
    localparam int ST = 7;
    localparam int SP = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b0;
    logic        pulse = 1'b0;
    logic        force_bad = 1'b0;
    logic [6:0]  ring;
    logic        osc_en, valid, ovf, err;
    logic [7:0]  coarse;
    logic [6:0]  fine;
    logic [3:0]  step;
    logic [11:0] width;
    int          ring_step = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    // Independent ring model: walk the transitions node by node from idle.
    function automatic logic [6:0] ring_pat(input int s);
        logic [6:0] p;
        for (int k = 0; k < ST; k++) p[k] = (k % 2 == 0);
        for (int i = 0; i < s; i++) p[i % ST] = ~p[i % ST];
        return p;
    endfunction

    function automatic int exp_coarse(input int t);
        int f = (t + ST) / SP;
        return (f > 255) ? 255 : f;
    endfunction

    function automatic int exp_width(input int t);
        int c = exp_coarse(t);
        int s = t % SP;
        return c * SP + s - ((s >= ST) ? SP : 0);
    endfunction

    assign ring = force_bad ? 7'b0000000 : ring_pat(ring_step % SP);

    always @(posedge clk) begin
        if (!rst_n || init) ring_step <= 0;
        else if (osc_en)    ring_step <= ring_step + 1;
    end

    tdc_pulse_digitizer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .init_i(init), .pulse_i(pulse), .ring_i(ring),
        .osc_en_o(osc_en), .coarse_o(coarse), .fine_o(fine), .step_o(step),
        .width_o(width), .valid_o(valid), .ovf_o(ovf), .err_o(err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_init();
        @(negedge clk);
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
    endtask

    task automatic drive_pulse(input int n, input bit expect_run);
        pulse = 1'b1;
        #0.5;
        check(expect_run ? "R2 enable follows pulse" : "R7 enable blocked",
              int'(osc_en), expect_run ? 1 : 0);
        repeat (n) @(negedge clk);
        pulse = 1'b0;
    endtask

    task automatic check_result(input string tag, input int t);
        check({tag, " R3 coarse"}, int'(coarse), exp_coarse(t));
        check({tag, " R4/R5 fine"}, int'(fine), int'(ring_pat(t % SP)));
        check({tag, " R5 step"}, int'(step), t % SP);
        check({tag, " R6 width"}, int'(width), exp_width(t));
        check({tag, " R7 valid"}, int'(valid), 1);
        check({tag, " R9 ovf"}, int'(ovf), ((t + ST) / SP > 255) ? 1 : 0);
        check({tag, " R10 err"}, int'(err), 0);
    endtask

    // One measurement; gap of 0 means a single pulse.
    task automatic measure(input string tag, input int n1, input int gap, input int n2);
        int t;
        do_init();
        drive_pulse(n1, 1'b1);
        t = n1;
        if (gap > 0) begin
            repeat (gap) @(negedge clk);
            if (gap == 1) check({tag, " R8 not locked in gap"}, int'(valid), 0);
            drive_pulse(n2, gap == 1);
            if (gap == 1) t = t + n2;
        end
        repeat (5) @(negedge clk);
        check_result(tag, t);
    endtask

    initial begin
        int n1, n2, g;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 coarse", int'(coarse), 0);
        check("R1 fine", int'(fine), 'h55);
        check("R1 width", int'(width), 0);
        check("R1 valid", int'(valid), 0);
        check("R1 ovf", int'(ovf), 0);
        check("R1 err", int'(err), 0);

        // Directed step boundaries around the tap fall and the period wrap
        measure("d1", 1, 0, 0);
        measure("d6", 6, 0, 0);
        measure("d7", 7, 0, 0);
        measure("d13", 13, 0, 0);
        measure("d14", 14, 0, 0);
        measure("d15", 15, 0, 0);
        measure("d21", 21, 0, 0);
        measure("d28", 28, 0, 0);

        // R8 summing and R7 rejection after a two-sample gap
        measure("sum", 10, 1, 9);
        measure("rej", 10, 2, 9);

        // R4/R7: late pulse after lock leaves the result untouched
        measure("late", 17, 0, 0);
        @(negedge clk);
        drive_pulse(6, 1'b0);
        repeat (3) @(negedge clk);
        check_result("late R4 held", 17);

        // R1 via initialize after a measurement
        do_init();
        check("R1 init coarse", int'(coarse), 0);
        check("R1 init fine", int'(fine), 'h55);
        check("R1 init valid", int'(valid), 0);

        // R9 saturation edges
        measure("sat255", 3563, 0, 0);
        measure("ovf", 3577, 0, 0);
        measure("ovf_long", 3600, 0, 0);

        // R10 illegal latched pattern
        do_init();
        force_bad = 1'b1;
        drive_pulse(1, 1'b1);
        repeat (5) @(negedge clk);
        check("R10 err", int'(err), 1);
        check("R10 width", int'(width), 0);
        check("R10 step", int'(step), 0);
        force_bad = 1'b0;

        // Random lengths and gaps
        for (int i = 0; i < 30; i++) begin
            n1 = 1 + int'($urandom % 60);
            n2 = 1 + int'($urandom % 40);
            g  = int'($urandom % 3);
            measure("rnd", n1, g, n2);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule